// File: doc/BRIEF.md
# Window Pixel Transfer Controller

This block takes a stream of 16-bit words written to a pixel data port and places them into a rectangular window of a byte-addressed frame buffer. A setup step checks the configured window corners, the pixel format code and the source select. If they are legal, it latches the window and loads a word counter with the transfer length. Each accepted word then goes out on a frame-buffer write port, one cycle later, with a computed byte address.

When the last word of a window has been accepted, the block pulses a completion flag. It also widens a dirty bounding box so that the box covers every region modified since the last refresh. A refresh consumer reads the box and pulses a clear input, which returns the box to an inverted, empty state. Setup runs in two cases: when the source select is written, and when a pixel word arrives while no words are outstanding. Pixel reordering for rotation and colour conversion happen elsewhere. This block only carries the two rotation bits latched at setup.

Top module: `wxfer_ctrl`

## Requirements
- R1: Bytes per pixel depend on `cfg_fmt`. Codes 1 give 2 bytes, codes 2 and 3 give 3 bytes, and codes 6 and 7 give 4 bytes. Every other code means 0 bytes, and setup fails on it.
- R2: Setup also fails when `cfg_src` is above 3, when `cfg_x1 < cfg_x0`, or when `cfg_y1 < cfg_y0`. A failed setup leaves an ongoing transfer and its remaining count untouched.
- R3: A successful setup loads floor(bpp × (x1−x0+1) × (y1−y0+1) / 2) words. Each accepted word decrements the count, and `xfer_busy` is high while the count is nonzero. `xfer_done` pulses for one cycle, in the cycle after the last word is accepted.
- R4: A `src_wr` pulse with a legal configuration restarts the transfer, even in the middle of one. The remaining count is reloaded and addressing begins again at the new window.
- R5: A `pix_wr` while `xfer_busy` is low first runs setup from the current configuration. If that setup fails, the word is dropped: no frame-buffer write occurs and `xfer_busy` stays low.
- R6: Each accepted word is driven on `fb_data`, with `fb_we` high, one cycle after it is accepted. The first word of a window goes to byte address y0 × pitch + x0 × bpp. Each further word adds 2 bytes. When the byte offset within a row reaches or passes bpp × width, the excess carries into the next row, which starts one pitch (`cfg_pitch`, latched at setup) further on.
- R7: On completion, the dirty box becomes left = min(left, x0), top = min(top, y0), right = max(right, x0+width), bottom = max(bottom, y0+height). The new box is visible together with `xfer_done`.
- R8: Reset and `dirty_clr` set the box to left = `disp_w`, right = 0, top = `disp_h`, bottom = 0. `dirty_empty` is high whenever right ≤ left.
- R9: When `dirty_clr` and a completing word fall in the same cycle, the clear is applied first. The resulting box is exactly the completed window.
- R10: `xfer_rot` shows the two rotation bits `cfg_rot` captured at the last successful setup. It changes at no other time.
- R11: When `pix_wr` and `src_wr` are high in the same cycle, setup runs and the pixel word is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_x0 | input | COORD_W | Window left column |
| cfg_y0 | input | COORD_W | Window top row |
| cfg_x1 | input | COORD_W | Window right column (inclusive) |
| cfg_y1 | input | COORD_W | Window bottom row (inclusive) |
| cfg_fmt | input | 4 | Pixel format code |
| cfg_src | input | 3 | Source select value |
| cfg_rot | input | 2 | Rotation selection bits |
| cfg_pitch | input | PITCH_W | Frame-buffer row pitch in bytes |
| disp_w | input | COORD_W+1 | Display width, used for the empty box |
| disp_h | input | COORD_W+1 | Display height, used for the empty box |
| src_wr | input | 1 | Source select write strobe (setup trigger) |
| pix_wr | input | 1 | Pixel port word write strobe |
| pix_data | input | 16 | Pixel port word |
| dirty_clr | input | 1 | Refresh consumed the dirty box |
| fb_we | output | 1 | Frame-buffer write enable |
| fb_addr | output | AW | Frame-buffer byte address |
| fb_data | output | 16 | Frame-buffer write word |
| xfer_busy | output | 1 | Words outstanding |
| xfer_done | output | 1 | One-cycle window completion pulse |
| xfer_rot | output | 2 | Rotation bits latched at setup |
| dirty_l | output | COORD_W+1 | Dirty box left edge |
| dirty_r | output | COORD_W+1 | Dirty box right edge (exclusive) |
| dirty_t | output | COORD_W+1 | Dirty box top edge |
| dirty_b | output | COORD_W+1 | Dirty box bottom edge (exclusive) |
| dirty_empty | output | 1 | Dirty box holds no area |

## Verification
The checker properties assume three things about the inputs:
- The window, format, rotation and pitch inputs hold steady during the cycle in which a setup can fire.
- `disp_w` and `disp_h` do not change between reset and a clear.
- Window corners stay inside the coordinate range, so an edge plus its span never exceeds the width of the box edges.

The stimulus respects these assumptions. It changes configuration only on the falling edge, before a strobe, keeps the display size fixed, and uses small windows well inside the display. It reaches the harder orderings on purpose: a restart in the middle of a transfer, a rejected setup while busy, simultaneous strobes, and a clear that lands together with a completion.

// File: rtl/wxfer_pkg.sv
// Shared definitions for the window pixel transfer controller.
// Assumes format codes are 4 bits wide and source select is 3 bits wide.
package wxfer_pkg;

    localparam int FMT_W   = 4;
    localparam int SRC_W   = 3;
    localparam int BPP_W   = 3;
    localparam int WORD_W  = 16;
    localparam logic [SRC_W-1:0] SRC_LEGAL_MAX = 3'd3;

    // Bytes per pixel for a format code; zero marks an illegal code.
    function automatic logic [BPP_W-1:0] fmt_bytes(input logic [FMT_W-1:0] code);
        case (code)
            4'd1:       return 3'd2;
            4'd2, 4'd3: return 3'd3;
            4'd6, 4'd7: return 3'd4;
            default:    return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/wxfer_setup.sv
// Combinational setup evaluator: validates the configured window, format and
// source, and derives the word count, start byte address and row length.
// Assumes x1/y1 are inclusive corners; the word count is floored.
module wxfer_setup
    import wxfer_pkg::*;
#(
    parameter int COORD_W = 10,
    parameter int PITCH_W = 13,
    parameter int AW      = 24
) (
    input  logic [COORD_W-1:0]     x0,
    input  logic [COORD_W-1:0]     y0,
    input  logic [COORD_W-1:0]     x1,
    input  logic [COORD_W-1:0]     y1,
    input  logic [FMT_W-1:0]       fmt,
    input  logic [SRC_W-1:0]       src,
    input  logic [PITCH_W-1:0]     pitch,
    output logic                   ok,
    output logic [2*COORD_W+3:0]   words,
    output logic [AW-1:0]          start,
    output logic [COORD_W+3:0]     row_bytes,
    output logic [COORD_W:0]       span_x,
    output logic [COORD_W:0]       span_y
);
    localparam int SPAN_W = COORD_W + 1;
    localparam int ROWB_W = COORD_W + 4;
    localparam int TOT_W  = ROWB_W + SPAN_W;

    logic [BPP_W-1:0] bpp;
    logic [TOT_W-1:0] total_bytes;

    // Decode the format and size the window.
    always_comb begin
        bpp         = fmt_bytes(fmt);
        span_x      = SPAN_W'(x1) - SPAN_W'(x0) + SPAN_W'(1);
        span_y      = SPAN_W'(y1) - SPAN_W'(y0) + SPAN_W'(1);
        row_bytes   = ROWB_W'(bpp) * ROWB_W'(span_x);
        total_bytes = TOT_W'(row_bytes) * TOT_W'(span_y);
        words       = total_bytes[TOT_W-1:1];
        start       = AW'(y0) * AW'(pitch) + AW'(x0) * AW'(bpp);
        ok          = (src <= SRC_LEGAL_MAX) && (bpp != '0) &&
                      (x1 >= x0) && (y1 >= y0);
    end

endmodule

// File: rtl/wxfer_walker.sv
// Transfer sequencer: holds the remaining word count and the window's
// addressing state, accepts pixel words, drives the frame-buffer port and
// flags the completing word. Assumes the setup inputs reflect current config.
module wxfer_walker
    import wxfer_pkg::*;
#(
    parameter int COORD_W = 10,
    parameter int PITCH_W = 13,
    parameter int AW      = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   src_wr,
    input  logic                   pix_wr,
    input  logic [WORD_W-1:0]      pix_data,
    input  logic [1:0]             rot_in,
    input  logic [COORD_W-1:0]     x0,
    input  logic [COORD_W-1:0]     y0,
    input  logic [PITCH_W-1:0]     pitch,
    input  logic                   ok,
    input  logic [2*COORD_W+3:0]   words,
    input  logic [AW-1:0]          start,
    input  logic [COORD_W+3:0]     row_bytes,
    input  logic [COORD_W:0]       span_x,
    input  logic [COORD_W:0]       span_y,
    output logic                   fb_we,
    output logic [AW-1:0]          fb_addr,
    output logic [WORD_W-1:0]      fb_data,
    output logic                   busy,
    output logic                   done,
    output logic [1:0]             rot,
    output logic                   fire,
    output logic [COORD_W:0]       win_x0,
    output logic [COORD_W:0]       win_y0,
    output logic [COORD_W:0]       win_x1,
    output logic [COORD_W:0]       win_y1
);
    localparam int SPAN_W = COORD_W + 1;
    localparam int ROWB_W = COORD_W + 4;
    localparam int CNT_W  = 2 * COORD_W + 4;

    logic [CNT_W-1:0]   rem_q;
    logic [AW-1:0]      base_q;
    logic [ROWB_W-1:0]  col_q;
    logic [ROWB_W-1:0]  rowb_q;
    logic [PITCH_W-1:0] pitch_q;
    logic [COORD_W-1:0] wx_q, wy_q;
    logic [SPAN_W-1:0]  sx_q, sy_q;

    logic               idle, load, accept;
    logic [CNT_W-1:0]   e_rem;
    logic [AW-1:0]      e_base;
    logic [ROWB_W-1:0]  e_col, e_rowb;
    logic [PITCH_W-1:0] e_pitch;
    logic [COORD_W-1:0] e_wx, e_wy;
    logic [SPAN_W-1:0]  e_sx, e_sy;
    logic [ROWB_W:0]    col_nx;
    logic               wrap;
    logic [ROWB_W-1:0]  col_adv;
    logic [AW-1:0]      base_adv;

    // Decide setup and acceptance, and pick the state the word sees.
    always_comb begin
        idle    = (rem_q == '0);
        load    = (src_wr || (pix_wr && idle)) && ok;
        accept  = pix_wr && !src_wr && (!idle || ok);
        e_rem   = idle ? words     : rem_q;
        e_base  = idle ? start     : base_q;
        e_col   = idle ? '0        : col_q;
        e_rowb  = idle ? row_bytes : rowb_q;
        e_pitch = idle ? pitch     : pitch_q;
        e_wx    = idle ? x0        : wx_q;
        e_wy    = idle ? y0        : wy_q;
        e_sx    = idle ? span_x    : sx_q;
        e_sy    = idle ? span_y    : sy_q;
    end

    // Step the byte offset by one word, carrying into the next row.
    always_comb begin
        col_nx   = {1'b0, e_col} + (ROWB_W+1)'(2);
        wrap     = (col_nx >= {1'b0, e_rowb});
        col_adv  = wrap ? ROWB_W'(col_nx - {1'b0, e_rowb}) : col_nx[ROWB_W-1:0];
        base_adv = wrap ? (e_base + AW'(e_pitch)) : e_base;
    end

    // Report the completing window to the dirty tracker.
    always_comb begin
        fire   = accept && (e_rem == CNT_W'(1));
        win_x0 = SPAN_W'(e_wx);
        win_y0 = SPAN_W'(e_wy);
        win_x1 = SPAN_W'(e_wx) + e_sx;
        win_y1 = SPAN_W'(e_wy) + e_sy;
        busy   = !idle;
    end

    // Register setup results, transfer progress and frame-buffer outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            base_q  <= '0;
            col_q   <= '0;
            rowb_q  <= '0;
            pitch_q <= '0;
            wx_q    <= '0;
            wy_q    <= '0;
            sx_q    <= '0;
            sy_q    <= '0;
            rot     <= '0;
            fb_we   <= 1'b0;
            fb_addr <= '0;
            fb_data <= '0;
            done    <= 1'b0;
        end else begin
            fb_we <= accept;
            done  <= fire;
            if (load) begin
                rem_q   <= words;
                base_q  <= start;
                col_q   <= '0;
                rowb_q  <= row_bytes;
                pitch_q <= pitch;
                wx_q    <= x0;
                wy_q    <= y0;
                sx_q    <= span_x;
                sy_q    <= span_y;
                rot     <= rot_in;
            end
            if (accept) begin
                fb_addr <= e_base + AW'(e_col);
                fb_data <= pix_data;
                rem_q   <= e_rem - CNT_W'(1);
                base_q  <= base_adv;
                col_q   <= col_adv;
            end
        end
    end

endmodule

// File: rtl/wxfer_dirty.sv
// Dirty bounding-box tracker: grows the box by each completed window and
// returns it to the inverted empty state on reset or clear.
// Assumes clear is applied before a merge arriving in the same cycle.
module wxfer_dirty #(
    parameter int DIM_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fire,
    input  logic [DIM_W-1:0] win_x0,
    input  logic [DIM_W-1:0] win_y0,
    input  logic [DIM_W-1:0] win_x1,
    input  logic [DIM_W-1:0] win_y1,
    input  logic [DIM_W-1:0] disp_w,
    input  logic [DIM_W-1:0] disp_h,
    output logic [DIM_W-1:0] box_l,
    output logic [DIM_W-1:0] box_r,
    output logic [DIM_W-1:0] box_t,
    output logic [DIM_W-1:0] box_b,
    output logic             empty
);
    logic [DIM_W-1:0] b_l, b_r, b_t, b_b;
    logic [DIM_W-1:0] n_l, n_r, n_t, n_b;

    // Start from the empty box on clear, then merge the finished window.
    always_comb begin
        b_l = clr ? disp_w : box_l;
        b_r = clr ? '0     : box_r;
        b_t = clr ? disp_h : box_t;
        b_b = clr ? '0     : box_b;
        n_l = b_l;
        n_r = b_r;
        n_t = b_t;
        n_b = b_b;
        if (fire) begin
            n_l = (win_x0 < b_l) ? win_x0 : b_l;
            n_t = (win_y0 < b_t) ? win_y0 : b_t;
            n_r = (win_x1 > b_r) ? win_x1 : b_r;
            n_b = (win_y1 > b_b) ? win_y1 : b_b;
        end
    end

    // Hold the box edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            box_l <= disp_w;
            box_r <= '0;
            box_t <= disp_h;
            box_b <= '0;
        end else begin
            box_l <= n_l;
            box_r <= n_r;
            box_t <= n_t;
            box_b <= n_b;
        end
    end

    // A box without positive width holds no area.
    always_comb empty = (box_r <= box_l);

endmodule

// File: rtl/wxfer_ctrl.sv
// Top of the window pixel transfer controller: joins the setup evaluator,
// the transfer sequencer and the dirty-box tracker.
// Assumes configuration inputs are stable in any cycle a setup may fire.
module wxfer_ctrl
    import wxfer_pkg::*;
#(
    parameter int COORD_W = 10,
    parameter int PITCH_W = 13,
    parameter int AW      = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] cfg_x0,
    input  logic [COORD_W-1:0] cfg_y0,
    input  logic [COORD_W-1:0] cfg_x1,
    input  logic [COORD_W-1:0] cfg_y1,
    input  logic [3:0]         cfg_fmt,
    input  logic [2:0]         cfg_src,
    input  logic [1:0]         cfg_rot,
    input  logic [PITCH_W-1:0] cfg_pitch,
    input  logic [COORD_W:0]   disp_w,
    input  logic [COORD_W:0]   disp_h,
    input  logic               src_wr,
    input  logic               pix_wr,
    input  logic [15:0]        pix_data,
    input  logic               dirty_clr,
    output logic               fb_we,
    output logic [AW-1:0]      fb_addr,
    output logic [15:0]        fb_data,
    output logic               xfer_busy,
    output logic               xfer_done,
    output logic [1:0]         xfer_rot,
    output logic [COORD_W:0]   dirty_l,
    output logic [COORD_W:0]   dirty_r,
    output logic [COORD_W:0]   dirty_t,
    output logic [COORD_W:0]   dirty_b,
    output logic               dirty_empty
);
    localparam int DIM_W  = COORD_W + 1;
    localparam int ROWB_W = COORD_W + 4;
    localparam int CNT_W  = 2 * COORD_W + 4;

    logic              s_ok;
    logic [CNT_W-1:0]  s_words;
    logic [AW-1:0]     s_start;
    logic [ROWB_W-1:0] s_rowb;
    logic [DIM_W-1:0]  s_sx, s_sy;
    logic              m_fire;
    logic [DIM_W-1:0]  m_x0, m_y0, m_x1, m_y1;

    wxfer_setup #(.COORD_W(COORD_W), .PITCH_W(PITCH_W), .AW(AW)) u_setup (
        .x0(cfg_x0), .y0(cfg_y0), .x1(cfg_x1), .y1(cfg_y1),
        .fmt(cfg_fmt), .src(cfg_src), .pitch(cfg_pitch),
        .ok(s_ok), .words(s_words), .start(s_start),
        .row_bytes(s_rowb), .span_x(s_sx), .span_y(s_sy)
    );

    wxfer_walker #(.COORD_W(COORD_W), .PITCH_W(PITCH_W), .AW(AW)) u_walk (
        .clk(clk), .rst_n(rst_n), .src_wr(src_wr), .pix_wr(pix_wr),
        .pix_data(pix_data), .rot_in(cfg_rot),
        .x0(cfg_x0), .y0(cfg_y0), .pitch(cfg_pitch),
        .ok(s_ok), .words(s_words), .start(s_start), .row_bytes(s_rowb),
        .span_x(s_sx), .span_y(s_sy),
        .fb_we(fb_we), .fb_addr(fb_addr), .fb_data(fb_data),
        .busy(xfer_busy), .done(xfer_done), .rot(xfer_rot),
        .fire(m_fire), .win_x0(m_x0), .win_y0(m_y0),
        .win_x1(m_x1), .win_y1(m_y1)
    );

    wxfer_dirty #(.DIM_W(DIM_W)) u_dirty (
        .clk(clk), .rst_n(rst_n), .clr(dirty_clr), .fire(m_fire),
        .win_x0(m_x0), .win_y0(m_y0), .win_x1(m_x1), .win_y1(m_y1),
        .disp_w(disp_w), .disp_h(disp_h),
        .box_l(dirty_l), .box_r(dirty_r), .box_t(dirty_t), .box_b(dirty_b),
        .empty(dirty_empty)
    );

endmodule

// File: rtl/wxfer_ctrl_chk.sv
// Property checker for the window pixel transfer controller, bound to the top.
// Assumes it observes the top's ports only.
module wxfer_ctrl_chk #(
    parameter int COORD_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             src_wr,
    input logic             pix_wr,
    input logic             dirty_clr,
    input logic             fb_we,
    input logic             xfer_busy,
    input logic             xfer_done,
    input logic [1:0]       xfer_rot,
    input logic [COORD_W:0] dirty_l,
    input logic [COORD_W:0] dirty_r,
    input logic             dirty_empty
);
    // R6: a frame-buffer write only follows an accepted pixel word.
    assert_we_after_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> ($past(pix_wr) && !$past(src_wr)));

    // R3: completion coincides with the last write and an idle counter.
    assert_done_last_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (fb_we && !xfer_busy));

    // R3: the counter only drains to idle through a completion.
    assert_busy_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_busy) |-> xfer_done);

    // R8: a clear without a merge leaves an empty box.
    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dirty_clr) && !xfer_done) |-> (dirty_empty && (dirty_r <= dirty_l)));

    // R7: a completed window always leaves area in the box.
    assert_box_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !dirty_empty);

    // R10: rotation bits move only after a setup strobe.
    assert_rot_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(src_wr) && !$past(pix_wr)) |-> $stable(xfer_rot));

endmodule

bind wxfer_ctrl wxfer_ctrl_chk #(.COORD_W(COORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_wr(src_wr), .pix_wr(pix_wr),
    .dirty_clr(dirty_clr), .fb_we(fb_we), .xfer_busy(xfer_busy),
    .xfer_done(xfer_done), .xfer_rot(xfer_rot),
    .dirty_l(dirty_l), .dirty_r(dirty_r), .dirty_empty(dirty_empty)
);

// File: tb/tb_wxfer_ctrl.sv
`timescale 1ns/1ps
module tb_wxfer_ctrl;
    localparam int COORD_W = 10;
    localparam int PITCH_W = 13;
    localparam int AW      = 24;
    localparam int DW      = 100;
    localparam int DH      = 80;
    localparam int PITCH   = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [COORD_W-1:0] cfg_x0 = '0, cfg_y0 = '0, cfg_x1 = '0, cfg_y1 = '0;
    logic [3:0] cfg_fmt = 4'd1;
    logic [2:0] cfg_src = 3'd0;
    logic [1:0] cfg_rot = 2'd0;
    logic [PITCH_W-1:0] cfg_pitch = PITCH_W'(PITCH);
    logic [COORD_W:0] disp_w = (COORD_W+1)'(DW);
    logic [COORD_W:0] disp_h = (COORD_W+1)'(DH);
    logic src_wr = 1'b0, pix_wr = 1'b0, dirty_clr = 1'b0;
    logic [15:0] pix_data = 16'h0;
    logic fb_we, xfer_busy, xfer_done, dirty_empty;
    logic [AW-1:0] fb_addr;
    logic [15:0] fb_data;
    logic [1:0] xfer_rot;
    logic [COORD_W:0] dirty_l, dirty_r, dirty_t, dirty_b;

    int n_checks = 0;
    int n_fail = 0;
    bit cmp_on = 0;

    wxfer_ctrl #(.COORD_W(COORD_W), .PITCH_W(PITCH_W), .AW(AW)) dut (.*);

    always #2.5 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int m_rem, m_k, m_start, m_rowb, m_pitch, m_wx, m_wy, m_ww, m_wh, m_rot;
    int m_we, m_addr, m_data, m_done, m_l, m_r, m_t, m_b;

    function automatic int bpp_of(input int f);
        case (f)
            1: return 2;
            2, 3: return 3;
            6, 7: return 4;
            default: return 0;
        endcase
    endfunction

    task automatic model_setup();
        int b;
        b = bpp_of(int'(cfg_fmt));
        if (cfg_src > 3 || b == 0 || cfg_x1 < cfg_x0 || cfg_y1 < cfg_y0) return;
        m_wx = int'(cfg_x0); m_wy = int'(cfg_y0);
        m_ww = int'(cfg_x1) - int'(cfg_x0) + 1;
        m_wh = int'(cfg_y1) - int'(cfg_y0) + 1;
        m_rem = (b * m_ww * m_wh) / 2;
        m_k = 0;
        m_pitch = int'(cfg_pitch);
        m_rowb = b * m_ww;
        m_start = m_wy * m_pitch + m_wx * b;
        m_rot = int'(cfg_rot);
    endtask

    always @(posedge clk) begin
        bit fire;
        cmp_on <= 1;
        if (!rst_n) begin
            m_rem = 0; m_k = 0; m_we = 0; m_done = 0; m_rot = 0;
            m_addr = 0; m_data = 0;
            m_l = DW; m_r = 0; m_t = DH; m_b = 0;
        end else begin
            fire = 0; m_we = 0; m_done = 0;
            if (src_wr) model_setup();
            else if (pix_wr) begin
                if (m_rem == 0) model_setup();
                if (m_rem > 0) begin
                    m_we = 1;
                    m_addr = m_start + ((2*m_k) / m_rowb) * m_pitch + (2*m_k) % m_rowb;
                    m_data = int'(pix_data);
                    m_k++; m_rem--;
                    if (m_rem == 0) begin m_done = 1; fire = 1; end
                end
            end
            if (dirty_clr) begin m_l = DW; m_r = 0; m_t = DH; m_b = 0; end
            if (fire) begin
                if (m_wx < m_l) m_l = m_wx;
                if (m_wy < m_t) m_t = m_wy;
                if (m_wx + m_ww > m_r) m_r = m_wx + m_ww;
                if (m_wy + m_wh > m_b) m_b = m_wy + m_wh;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R3 busy", int'(xfer_busy), int'(m_rem != 0));
            chk("R3 done", int'(xfer_done), m_done);
            chk("R6 fb_we", int'(fb_we), m_we);
            if (m_we != 0) begin
                chk("R6 fb_addr", int'(fb_addr), m_addr);
                chk("R6 fb_data", int'(fb_data), m_data);
            end
            chk("R10 rot", int'(xfer_rot), m_rot);
            chk("R7 left", int'(dirty_l), m_l);
            chk("R7 right", int'(dirty_r), m_r);
            chk("R7 top", int'(dirty_t), m_t);
            chk("R7 bottom", int'(dirty_b), m_b);
            chk("R8 empty", int'(dirty_empty), int'(m_r <= m_l));
        end
    end

    // ---------------- stimulus helpers ----------------
    int seq = 0;

    task automatic step(input logic s, input logic p, input logic c);
        src_wr = s; pix_wr = p; dirty_clr = c;
        seq++;
        pix_data = 16'(seq * 16'h1357 + 16'h00a5);
        @(negedge clk);
        src_wr = 0; pix_wr = 0; dirty_clr = 0;
    endtask

    task automatic set_win(input int x0, input int y0, input int x1, input int y1,
                           input int f, input int src, input int rot);
        cfg_x0 = COORD_W'(x0); cfg_y0 = COORD_W'(y0);
        cfg_x1 = COORD_W'(x1); cfg_y1 = COORD_W'(y1);
        cfg_fmt = 4'(f); cfg_src = 3'(src); cfg_rot = 2'(rot);
    endtask

    task automatic drain(output int n);
        n = 0;
        while (xfer_busy && n < 64) begin
            step(0, 1, 0);
            n++;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Reset state
        chk("R8 reset empty", int'(dirty_empty), 1);
        chk("R8 reset left", int'(dirty_l), DW);
        chk("R8 reset top", int'(dirty_t), DH);
        chk("R3 reset idle", int'(xfer_busy), 0);

        // R1 / R3: every format code on a 2x1 window
        for (int f = 0; f < 16; f++) begin
            set_win(0, 0, 1, 0, f, 0, 0);
            step(1, 0, 0);
            chk("R1 setup legal", int'(xfer_busy), int'(bpp_of(f) != 0));
            drain(n);
            chk("R3 word count", n, bpp_of(f));
        end

        // R5: illegal format with idle pixel write drops the word
        set_win(0, 0, 0, 0, 4, 0, 0);
        step(0, 1, 0);
        chk("R5 dropped write", int'(fb_we), 0);
        chk("R5 stays idle", int'(xfer_busy), 0);

        // R5 / R6: idle pixel write triggers setup, 3-byte rows straddle words
        set_win(5, 3, 7, 4, 2, 0, 1);
        step(0, 1, 0);
        chk("R5 implicit setup", int'(fb_we), 1);
        chk("R6 start address", int'(fb_addr), 3*PITCH + 5*3);
        for (int i = 0; i < 5; i++) step(0, 1, 0);
        chk("R6 row carry address", int'(fb_addr), 3*PITCH + 5*3 + PITCH + 1);
        drain(n);
        chk("R3 remaining words", n, 3);

        // R2: failed setups while idle and while busy
        set_win(4, 1, 2, 2, 1, 0, 0);
        step(1, 0, 0);
        chk("R2 end before start", int'(xfer_busy), 0);
        set_win(2, 1, 4, 2, 1, 0, 0);
        step(1, 0, 0);
        step(0, 1, 0);
        step(0, 1, 0);
        set_win(2, 1, 4, 2, 1, 5, 2);
        step(1, 0, 0);
        chk("R2 bad source keeps busy", int'(xfer_busy), 1);
        chk("R10 rot unchanged", int'(xfer_rot), 0);
        drain(n);
        chk("R2 count untouched", n, 4);

        // R4 / R10: restart mid-transfer
        set_win(2, 1, 4, 2, 1, 0, 0);
        step(1, 0, 0);
        step(0, 1, 0);
        step(0, 1, 0);
        set_win(10, 0, 10, 1, 6, 2, 3);
        step(1, 0, 0);
        chk("R10 rot latched", int'(xfer_rot), 3);
        drain(n);
        chk("R4 restart count", n, 4);

        // R11: simultaneous strobes
        set_win(20, 20, 20, 20, 1, 0, 0);
        step(1, 1, 0);
        chk("R11 word dropped", int'(fb_we), 0);
        chk("R11 setup ran", int'(xfer_busy), 1);
        step(0, 1, 0);
        chk("R3 single word done", int'(xfer_done), 1);

        // R9: clear and completion in the same cycle
        set_win(40, 30, 40, 30, 1, 0, 0);
        step(1, 0, 0);
        step(0, 1, 1);
        chk("R9 left", int'(dirty_l), 40);
        chk("R9 right", int'(dirty_r), 41);
        chk("R9 top", int'(dirty_t), 30);
        chk("R9 bottom", int'(dirty_b), 31);

        // R8: clear alone
        step(0, 0, 1);
        chk("R8 clear empty", int'(dirty_empty), 1);
        chk("R8 clear left", int'(dirty_l), DW);
        chk("R8 clear bottom", int'(dirty_b), 0);

        // R7: two windows merge into one box
        set_win(2, 1, 4, 2, 1, 0, 0);
        step(1, 0, 0);
        drain(n);
        set_win(10, 20, 11, 20, 3, 1, 0);
        step(1, 0, 0);
        drain(n);
        chk("R7 merged left", int'(dirty_l), 2);
        chk("R7 merged right", int'(dirty_r), 12);
        chk("R7 merged top", int'(dirty_t), 1);
        chk("R7 merged bottom", int'(dirty_b), 21);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule